// File: doc/BRIEF.md
# Pseudo-static RAM refresh controller

This block holds the refresh logic of a pseudo-static RAM. It decides each clock which row of the array is opened next, and it takes that row from one of two sources. The first is the external address, which is used for ordinary accesses and for refreshes triggered by chip-enable alone. The second is an internal row counter, which is used for refreshes triggered by the refresh strobe. All inputs are sampled on the rising clock edge. Strobe and chip-enable edges are found by comparing each sample with the one before it.

A single strobe pulse starts one auto refresh at the counter's row. If the strobe stays low beyond a threshold, the controller moves into self refresh. In that mode a free-running timer opens the next counter row once per period, until the strobe is released. A recovery interval follows the release. A chip-enable falling edge that arrives while a refresh is running, or while the block is recovering, is held pending and is served once the block is idle. The busy flag is high for as long as the access is held back.

Top module: `psram_rfsh_ctrl`

## Requirements
- R1: After reset `row_act` and `busy` are 0, `row_addr` is 0 and the internal row counter is 0.
- R2: In idle, a falling `ce_n` sampled with `rfsh_n` high raises `row_act` one cycle later. `row_addr` then equals `addr[ROW_W-1:0]`, the upper address bits have no effect, and `busy` stays 0.
- R3: Every row activation keeps `row_act` high for exactly `ACT_CYC` cycles, and `row_addr` holds steady throughout.
- R4: In idle, a falling `rfsh_n` sampled with `ce_n` high raises `row_act` and `busy` one cycle later, with `row_addr` equal to the row counter.
- R5: The row counter advances by one after each counter-sourced activation and wraps modulo 2^ROW_W. External-address activations leave it unchanged.
- R6: A falling `rfsh_n` sampled while `ce_n` is low starts no activation.
- R7: If `rfsh_n` is held low for exactly `SELF_THRESH` samples, self refresh does not start. If it is held low for `SELF_THRESH`+1 samples, self refresh starts.
- R8: In self refresh the first timed activation begins `SELF_THRESH`+`SELF_PERIOD` cycles after the auto refresh that the strobe started. Further activations follow every `SELF_PERIOD` cycles on consecutive counter rows, and `busy` stays high.
- R9: When `rfsh_n` is sampled high while in self refresh between activations, `busy` stays high for exactly `RECOV_CYC` more cycles and then falls.
- R10: A falling `ce_n` sampled while `busy` is high sets `busy` one cycle later and stores the low address bits. The stored row is activated one cycle after recovery ends, and `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| addr | input | ADDR_W | External address; only the low ROW_W bits select a row |
| row_addr | output | ROW_W | Row being activated |
| row_act | output | 1 | Row-activate strobe |
| busy | output | 1 | Refresh or recovery in progress, or an access is pending |

## Verification
Activations started by an edge appear one cycle after the edge is sampled. A timed activation appears `SELF_THRESH`+k·`SELF_PERIOD` cycles after the strobe fall. After release, `busy` falls `RECOV_CYC` cycles later, or one cycle after that when an access is pending. The bench drives inputs on the falling clock edge and checks the first output on the next falling edge. A monitor stamps every activation with its cycle number and pulse width. The timed checks compare these stamp differences with the parameter sums above. Recovery is measured by counting consecutive busy samples after release, which keeps every comparison to exact cycle counts.

// File: rtl/psram_rfsh_pkg.sv
package psram_rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACC,
        ST_AUTO,
        ST_SWAIT,
        ST_SACT,
        ST_RECOV
    } rf_state_e;

endpackage

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] cnt
);
    logic [ROW_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rfsh_self_timer.sv
module rfsh_self_timer #(
    parameter int THRESH = 2000,
    parameter int PERIOD = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_low,
    input  logic run,
    output logic self_req,
    output logic tick
);
    localparam int LW = $clog2(THRESH + 1);
    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [LW-1:0] LOW_LIM  = LW'(THRESH);
    localparam logic [PW-1:0] PER_LAST = PW'(PERIOD - 1);

    logic [LW-1:0] low_d, low_q;
    logic [PW-1:0] per_d, per_q;

    always_comb begin
        low_d = low_q;
        if (!strobe_low)          low_d = '0;
        else if (low_q != LOW_LIM) low_d = low_q + 1'b1;

        per_d = per_q;
        if (!run)                  per_d = '0;
        else if (per_q == PER_LAST) per_d = '0;
        else                       per_d = per_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
            per_q <= '0;
        end else begin
            low_q <= low_d;
            per_q <= per_d;
        end
    end

    assign self_req = (low_q == LOW_LIM);
    assign tick     = run && (per_q == PER_LAST);
endmodule

// File: rtl/row_src_mux.sv
module row_src_mux #(
    parameter int ADDR_W = 16,
    parameter int ROW_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ROW_W-1:0]  pend_row,
    input  logic [ROW_W-1:0]  int_row,
    input  logic              use_pend,
    input  logic              sel_int,
    output logic [ROW_W-1:0]  ext_lo,
    output logic [ROW_W-1:0]  row_sel
);
    assign ext_lo = addr[ROW_W-1:0];

    generate
        if (ADDR_W > ROW_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:ROW_W];
        end
    endgenerate

    always_comb begin
        if (sel_int)       row_sel = int_row;
        else if (use_pend) row_sel = pend_row;
        else               row_sel = ext_lo;
    end
endmodule

// File: rtl/psram_rfsh_ctrl.sv
module psram_rfsh_ctrl
    import psram_rfsh_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int ROW_W       = 9,
    parameter int ACT_CYC     = 4,
    parameter int SELF_THRESH = 2000,
    parameter int REF_WINDOW  = 2000000,
    parameter int SELF_PERIOD = REF_WINDOW / (2 * (1 << ROW_W)),
    parameter int RECOV_CYC   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              rfsh_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row_addr,
    output logic              row_act,
    output logic              busy
);
    localparam int CMAX = (ACT_CYC > RECOV_CYC) ? ACT_CYC : RECOV_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] ACT_LAST = CW'(ACT_CYC - 1);
    localparam logic [CW-1:0] REC_LAST = CW'(RECOV_CYC - 1);

    typedef struct packed {
        rf_state_e        st;
        logic [CW-1:0]    cnt;
        logic [ROW_W-1:0] row;
        logic             pend;
        logic [ROW_W-1:0] pend_row;
        logic             ce_prev;
        logic             rf_prev;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_IDLE, cnt: '0, row: '0, pend: 1'b0,
        pend_row: '0, ce_prev: 1'b1, rf_prev: 1'b1
    };

    ctl_t ctl_d, ctl_q;

    logic             ce_fall, rf_fall;
    logic             sel_int, step, run_self;
    logic             self_req, self_tick;
    logic [ROW_W-1:0] int_row, ext_lo, row_sel;

    assign ce_fall  = ctl_q.ce_prev && !ce_n;
    assign rf_fall  = ctl_q.rf_prev && !rfsh_n;
    assign run_self = (ctl_q.st == ST_SWAIT) || (ctl_q.st == ST_SACT);
    assign sel_int  = (ctl_q.st == ST_SWAIT) ||
                      ((ctl_q.st == ST_IDLE) && !ctl_q.pend && !(ce_fall && rfsh_n));

    rfsh_row_counter #(.ROW_W(ROW_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .cnt   (int_row)
    );

    rfsh_self_timer #(.THRESH(SELF_THRESH), .PERIOD(SELF_PERIOD)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_low (!rfsh_n),
        .run        (run_self),
        .self_req   (self_req),
        .tick       (self_tick)
    );

    row_src_mux #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_mux (
        .addr     (addr),
        .pend_row (ctl_q.pend_row),
        .int_row  (int_row),
        .use_pend (ctl_q.pend),
        .sel_int  (sel_int),
        .ext_lo   (ext_lo),
        .row_sel  (row_sel)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.ce_prev = ce_n;
        ctl_d.rf_prev = rfsh_n;
        step          = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ctl_q.pend) begin
                    ctl_d.st   = ST_ACC;
                    ctl_d.cnt  = ACT_LAST;
                    ctl_d.row  = row_sel;
                    ctl_d.pend = 1'b0;
                end else if (ce_fall && rfsh_n) begin
                    ctl_d.st  = ST_ACC;
                    ctl_d.cnt = ACT_LAST;
                    ctl_d.row = row_sel;
                end else if (rf_fall && ce_n) begin
                    ctl_d.st  = ST_AUTO;
                    ctl_d.cnt = ACT_LAST;
                    ctl_d.row = row_sel;
                end else if (self_req && !rfsh_n && ce_n) begin
                    ctl_d.st = ST_SWAIT;
                end
            end
            ST_ACC: begin
                if (ctl_q.cnt == '0) ctl_d.st  = ST_IDLE;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            ST_AUTO: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st = ST_IDLE;
                    step     = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_SWAIT: begin
                if (rfsh_n) begin
                    ctl_d.st  = ST_RECOV;
                    ctl_d.cnt = REC_LAST;
                end else if (self_tick) begin
                    ctl_d.st  = ST_SACT;
                    ctl_d.cnt = ACT_LAST;
                    ctl_d.row = row_sel;
                end
            end
            ST_SACT: begin
                if (ctl_q.cnt == '0) begin
                    step = 1'b1;
                    if (rfsh_n) begin
                        ctl_d.st  = ST_RECOV;
                        ctl_d.cnt = REC_LAST;
                    end else begin
                        ctl_d.st = ST_SWAIT;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_RECOV: begin
                if (ctl_q.cnt == '0) ctl_d.st  = ST_IDLE;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (ce_fall && (ctl_q.st inside {ST_AUTO, ST_SWAIT, ST_SACT, ST_RECOV})) begin
            ctl_d.pend     = 1'b1;
            ctl_d.pend_row = ext_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign row_addr = ctl_q.row;
    assign row_act  = ctl_q.st inside {ST_ACC, ST_AUTO, ST_SACT};
    assign busy     = ctl_q.pend || (ctl_q.st inside {ST_AUTO, ST_SWAIT, ST_SACT, ST_RECOV});
endmodule

// File: rtl/rfsh_ctrl_chk.sv
module rfsh_ctrl_chk #(
    parameter int ADDR_W  = 16,
    parameter int ROW_W   = 9,
    parameter int ACT_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              rfsh_n,
    input logic [ADDR_W-1:0] addr,
    input logic [ROW_W-1:0]  row_addr,
    input logic              row_act,
    input logic              busy,
    input logic              self_tick
);
    localparam int HW = $clog2(ACT_CYC + 2);
    localparam logic [HW-1:0] HI_LIM = HW'(ACT_CYC);

    logic [HW-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       hi_q <= '0;
        else if (row_act) hi_q <= (hi_q == HI_LIM) ? hi_q : hi_q + 1'b1;
        else              hi_q <= '0;
    end

    p_ext_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_act) && !busy && !$past(busy) |-> row_addr == $past(addr[ROW_W-1:0]));

    p_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        row_act |-> hi_q < HI_LIM);

    p_row_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        row_act && $past(row_act) |-> $stable(row_addr));

    p_busy_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_act) |-> busy || !$past(ce_n));

    p_tick_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
        self_tick && !rfsh_n |=> row_act && busy);
endmodule

bind psram_rfsh_ctrl rfsh_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .ROW_W   (ROW_W),
    .ACT_CYC (ACT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .rfsh_n    (rfsh_n),
    .addr      (addr),
    .row_addr  (row_addr),
    .row_act   (row_act),
    .busy      (busy),
    .self_tick (self_tick)
);

// File: tb/sim_psram_rfsh_ctrl.sv
`timescale 1ns/1ps
module sim_psram_rfsh_ctrl;
    localparam int TA   = 8;
    localparam int TR   = 4;
    localparam int TACT = 3;
    localparam int TTH  = 20;
    localparam int TPER = 8;
    localparam int TREC = 5;
    localparam int NROW = 1 << TR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          rfsh_n = 1'b1;
    logic [TA-1:0] addr = '0;
    logic [TR-1:0] row_addr;
    logic          row_act, busy;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    int exp_cnt = 0;

    int cyc = 0;
    int n_act = 0;
    int act_row [0:511];
    int act_cyc [0:511];
    bit prev_act = 1'b0;
    int width = 0;
    int cur_row = 0;

    always #2 clk = ~clk;

    psram_rfsh_ctrl #(
        .ADDR_W(TA), .ROW_W(TR), .ACT_CYC(TACT), .SELF_THRESH(TTH),
        .REF_WINDOW(4096), .SELF_PERIOD(TPER), .RECOV_CYC(TREC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rfsh_n(rfsh_n), .addr(addr),
        .row_addr(row_addr), .row_act(row_act), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // activation monitor: pulse width and row stability (R3), log for timing
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (row_act && !prev_act) begin
                if (n_act < 512) begin
                    act_row[n_act] = int'(row_addr);
                    act_cyc[n_act] = cyc;
                end
                n_act++;
                width = 1;
                cur_row = int'(row_addr);
            end else if (row_act) begin
                width++;
                chk(int'(row_addr) == cur_row, "R3 row stable", int'(row_addr), cur_row);
            end else if (prev_act) begin
                chk(width == TACT, "R3 pulse width", width, TACT);
            end
            prev_act = row_act;
        end
    end

    task automatic count_busy(output int c);
        c = 0;
        @(negedge clk);
        while (busy && c < 1000) begin
            c++;
            @(negedge clk);
        end
    endtask

    task automatic do_auto(input int hold, input string tag);
        rfsh_n = 1'b0;
        @(negedge clk);
        chk(row_act == 1'b1, {tag, " R4 act"}, int'(row_act), 1);
        chk(int'(row_addr) == exp_cnt % NROW, {tag, " R5 counter row"}, int'(row_addr), exp_cnt % NROW);
        chk(busy == 1'b1, {tag, " R4 busy"}, int'(busy), 1);
        repeat (hold - 1) @(negedge clk);
        rfsh_n = 1'b1;
        exp_cnt++;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        int k0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(row_act == 1'b0, "R1 row_act", int'(row_act), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(row_addr == '0, "R1 row_addr", int'(row_addr), 0);

        // R2: accesses with varied upper bits
        for (int a = 0; a < 32; a++) begin
            logic [TA-1:0] v;
            v = TA'((a * 53 + 11) & 8'hFF);
            ce_n = 1'b0;
            addr = v;
            @(negedge clk);
            addr = ~v;
            chk(row_act == 1'b1, "R2 access act", int'(row_act), 1);
            chk(int'(row_addr) == int'(v[TR-1:0]), "R2 access row", int'(row_addr), int'(v[TR-1:0]));
            chk(busy == 1'b0, "R2 busy low", int'(busy), 0);
            repeat (TACT) @(negedge clk);
            ce_n = 1'b1;
            repeat (2) @(negedge clk);
        end

        // R4, R5: auto refresh sweep past the wrap
        for (int i = 0; i < NROW + 4; i++) begin
            do_auto(TACT + 2, "sweep");
            repeat (3) @(negedge clk);
        end

        // R6: strobe falls while chip enable is low
        k0 = n_act;
        ce_n = 1'b0;
        addr = 8'h35;
        @(negedge clk);
        rfsh_n = 1'b0;
        repeat (4) @(negedge clk);
        rfsh_n = 1'b1;
        repeat (3) @(negedge clk);
        rfsh_n = 1'b0;
        repeat (4) @(negedge clk);
        rfsh_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(n_act == k0 + 1, "R6 no extra activation", n_act - k0, 1);
        chk(busy == 1'b0, "R6 busy", int'(busy), 0);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
        do_auto(4, "post-R6");
        repeat (3) @(negedge clk);

        // R7 boundary: exactly the threshold, then one more sample
        do_auto(TTH, "thr");
        count_busy(c);
        chk(c == 0, "R7 no self at threshold", c, 0);
        repeat (2) @(negedge clk);
        do_auto(TTH + 1, "thr+1");
        count_busy(c);
        chk(c == TREC, "R7 self entered, R9 recovery", c, TREC);
        repeat (2) @(negedge clk);

        // R8, R9: longer self refresh
        k0 = n_act;
        rfsh_n = 1'b0;
        @(negedge clk);
        chk(int'(row_addr) == exp_cnt % NROW, "R8 auto row", int'(row_addr), exp_cnt % NROW);
        repeat (TTH + TPER) @(negedge clk);
        chk(busy == 1'b1, "R8 busy in self", int'(busy), 1);
        repeat (2 * TPER + TACT + 2 - 1) @(negedge clk);
        rfsh_n = 1'b1;
        count_busy(c);
        chk(c == TREC, "R9 recovery length", c, TREC);
        chk(n_act == k0 + 4, "R8 activation count", n_act - k0, 4);
        for (int j = 1; j < 4; j++) begin
            chk(act_cyc[k0 + j] - act_cyc[k0] == TTH + j * TPER, "R8 timed spacing",
                act_cyc[k0 + j] - act_cyc[k0], TTH + j * TPER);
            chk(act_row[k0 + j] == (exp_cnt + j) % NROW, "R8 timed row",
                act_row[k0 + j], (exp_cnt + j) % NROW);
        end
        exp_cnt += 4;
        repeat (2) @(negedge clk);

        // R10: access deferred during self refresh
        rfsh_n = 1'b0;
        @(negedge clk);
        repeat (TTH + 1) @(negedge clk);
        ce_n = 1'b0;
        addr = 8'hA7;
        @(negedge clk);
        addr = 8'h00;
        chk(busy == 1'b1, "R10 busy while pending", int'(busy), 1);
        repeat (TPER + TACT + 2 - 3) @(negedge clk);
        rfsh_n = 1'b1;
        count_busy(c);
        chk(c == TREC + 1, "R10 busy until served", c, TREC + 1);
        chk(row_act == 1'b1, "R10 deferred act", int'(row_act), 1);
        chk(int'(row_addr) == 7, "R10 deferred row", int'(row_addr), 7);
        exp_cnt += 2;
        repeat (TACT) @(negedge clk);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5: counter continuity after all modes
        do_auto(4, "final");
        repeat (6) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule